// File: doc/BRIEF.md
# Serial Port Host Register Interface

This block is the processor-side register front end of a classic byte-wide serial port controller. A host drives a 3-bit offset, separate read and write enables and an 8-bit write bus. The block turns each access into one of several register operations. Some offsets reach different storage depending on whether the access is a read or a write. Offsets 0 and 1 also depend on a bank-select bit held in the line control register. The block keeps the divisor, interrupt enable, FIFO control, line control, modem control and scratch bytes.

The block does not hold received or transmitted characters. A read of the receive slot produces a one-cycle pop strobe for the receive path and returns the byte that the receive path presents. A write of the transmit slot produces a one-cycle push strobe and a captured copy of the byte. Interrupt identification, line status and modem status come in from neighbouring logic, and this block only multiplexes them onto the read bus.

Every access is sampled on a rising clock edge. Read data, strobes and register contents all change at that same edge and are visible for the following cycle.

Top module: `uart_regfile_top`

## Requirements
- R1: After reset, every held register (divisor, interrupt enable, FIFO control, line control, modem control, scratch) reads zero. rdData, txData, txPush, rxPop and fifoCtlWr are also zero.
- R2: The bank bit is lineCtl bit 7. A write at offset 0 with that bit clear raises txPush for exactly the cycle after the write edge and sets txData to the written byte. No held register changes.
- R3: A read at offset 0 with the bank bit clear raises rxPop for the cycle after the read edge. The same cycle, rdData shows the rxData value sampled at that edge.
- R4: With the bank bit set, offset 0 reads and writes divisor bits 7:0 and offset 1 reads and writes divisor bits 15:8. These accesses produce no push or pop strobe.
- R5: With the bank bit clear, offset 1 reads and writes the interrupt enable byte.
- R6: A read at offset 2 returns intId. A write at offset 2 loads fifoCtl and raises fifoCtlWr for one cycle.
- R7: Offset 3 reads and writes lineCtl. Offset 4 reads and writes modemCtl.
- R8: A read at offset 5 returns lineStatus and a read at offset 6 returns modemStatus. A write at either offset changes no output.
- R9: Offset 7 reads and writes a scratch byte whose value appears on no output other than rdData.
- R10: rdData changes only at an edge that samples rdEn high. A read and a write in the same cycle use the register values from before that write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register offset |
| wrEn | input | 1 | Write enable |
| rdEn | input | 1 | Read enable |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Registered read data |
| rxData | input | 8 | Byte at the head of the receive path |
| intId | input | 8 | Interrupt identification from the arbiter |
| lineStatus | input | 8 | Line status from the serial engine |
| modemStatus | input | 8 | Modem status inputs |
| rxPop | output | 1 | One-cycle receive pop strobe |
| txPush | output | 1 | One-cycle transmit push strobe |
| txData | output | 8 | Byte captured with the push |
| divisor | output | 16 | Baud divisor |
| intEnable | output | 8 | Interrupt enable byte |
| fifoCtl | output | 8 | Last FIFO control byte written |
| fifoCtlWr | output | 1 | One-cycle strobe on a FIFO control write |
| lineCtl | output | 8 | Line control byte; bit 7 selects the bank |
| modemCtl | output | 8 | Modem control byte |

## Verification
Every held byte drives a port directly. A wrong decode therefore shows up in the cycle right after the offending write, on the register that should have changed or on the one that should not. A stale bank bit appears as a missing strobe together with a divisor change, or as an unexpected push or pop, again one cycle after the access. The side effects are judged edge by edge: a read-mux error corrupts the rdData of that read, and a spurious strobe is seen in the single cycle it occupies.

// File: rtl/uart_regs_pkg.sv
package uart_regs_pkg;

  localparam int OFS_W = 3;

  localparam logic [OFS_W-1:0] OFS_DATA  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_IEN   = 3'd1;
  localparam logic [OFS_W-1:0] OFS_IDFC  = 3'd2;
  localparam logic [OFS_W-1:0] OFS_LCTL  = 3'd3;
  localparam logic [OFS_W-1:0] OFS_MCTL  = 3'd4;
  localparam logic [OFS_W-1:0] OFS_LSTAT = 3'd5;
  localparam logic [OFS_W-1:0] OFS_MSTAT = 3'd6;
  localparam logic [OFS_W-1:0] OFS_SCR   = 3'd7;

  typedef enum logic [3:0] {
    SEL_RX,
    SEL_DIVLO,
    SEL_DIVHI,
    SEL_INTEN,
    SEL_INTID,
    SEL_LINECTL,
    SEL_MODEMCTL,
    SEL_LINESTAT,
    SEL_MODEMSTAT,
    SEL_SCRATCH
  } rdSel_e;

  typedef struct packed {
    logic   wrDivLo;
    logic   wrDivHi;
    logic   wrIntEn;
    logic   wrFifoCtl;
    logic   wrLineCtl;
    logic   wrModemCtl;
    logic   wrScratch;
    logic   wrTxHold;
    logic   rdStrobe;
    logic   rdRxPop;
    rdSel_e rdSel;
  } regStrobes_t;

endpackage

// File: rtl/uart_regs_ctrl.sv
module uart_regs_ctrl
  import uart_regs_pkg::*;
(
  input  logic [OFS_W-1:0] addr,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             bankSel,
  output regStrobes_t      strobes
);

  always_comb begin
    strobes          = '0;
    strobes.rdSel    = SEL_RX;
    strobes.rdStrobe = rdEn;

    if (wrEn) begin
      unique case (addr)
        OFS_DATA: begin
          if (bankSel) strobes.wrDivLo  = 1'b1;
          else         strobes.wrTxHold = 1'b1;
        end
        OFS_IEN: begin
          if (bankSel) strobes.wrDivHi = 1'b1;
          else         strobes.wrIntEn = 1'b1;
        end
        OFS_IDFC:  strobes.wrFifoCtl  = 1'b1;
        OFS_LCTL:  strobes.wrLineCtl  = 1'b1;
        OFS_MCTL:  strobes.wrModemCtl = 1'b1;
        OFS_SCR:   strobes.wrScratch  = 1'b1;
        default: ;
      endcase
    end

    unique case (addr)
      OFS_DATA: begin
        strobes.rdSel   = bankSel ? SEL_DIVLO : SEL_RX;
        strobes.rdRxPop = rdEn & ~bankSel;
      end
      OFS_IEN:   strobes.rdSel = bankSel ? SEL_DIVHI : SEL_INTEN;
      OFS_IDFC:  strobes.rdSel = SEL_INTID;
      OFS_LCTL:  strobes.rdSel = SEL_LINECTL;
      OFS_MCTL:  strobes.rdSel = SEL_MODEMCTL;
      OFS_LSTAT: strobes.rdSel = SEL_LINESTAT;
      OFS_MSTAT: strobes.rdSel = SEL_MODEMSTAT;
      default:   strobes.rdSel = SEL_SCRATCH;
    endcase
  end

endmodule

// File: rtl/uart_regs_dp.sv
module uart_regs_dp
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobes_t         strobes,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [DATA_W-1:0]   rxData,
  input  logic [DATA_W-1:0]   intId,
  input  logic [DATA_W-1:0]   lineStatus,
  input  logic [DATA_W-1:0]   modemStatus,
  output logic [DATA_W-1:0]   rdData,
  output logic                rxPop,
  output logic                txPush,
  output logic [DATA_W-1:0]   txData,
  output logic [2*DATA_W-1:0] divisor,
  output logic [DATA_W-1:0]   intEnable,
  output logic [DATA_W-1:0]   fifoCtl,
  output logic                fifoCtlWr,
  output logic [DATA_W-1:0]   lineCtl,
  output logic [DATA_W-1:0]   modemCtl
);

  logic [DATA_W-1:0] divLo, divHi, scratch, rdNext;

  always_comb begin
    unique case (strobes.rdSel)
      SEL_RX:        rdNext = rxData;
      SEL_DIVLO:     rdNext = divLo;
      SEL_DIVHI:     rdNext = divHi;
      SEL_INTEN:     rdNext = intEnable;
      SEL_INTID:     rdNext = intId;
      SEL_LINECTL:   rdNext = lineCtl;
      SEL_MODEMCTL:  rdNext = modemCtl;
      SEL_LINESTAT:  rdNext = lineStatus;
      SEL_MODEMSTAT: rdNext = modemStatus;
      default:       rdNext = scratch;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divLo     <= '0;
      divHi     <= '0;
      intEnable <= '0;
      fifoCtl   <= '0;
      lineCtl   <= '0;
      modemCtl  <= '0;
      scratch   <= '0;
      txData    <= '0;
      rdData    <= '0;
      txPush    <= 1'b0;
      rxPop     <= 1'b0;
      fifoCtlWr <= 1'b0;
    end else begin
      txPush    <= strobes.wrTxHold;
      rxPop     <= strobes.rdRxPop;
      fifoCtlWr <= strobes.wrFifoCtl;
      if (strobes.wrDivLo)    divLo     <= wrData;
      if (strobes.wrDivHi)    divHi     <= wrData;
      if (strobes.wrIntEn)    intEnable <= wrData;
      if (strobes.wrFifoCtl)  fifoCtl   <= wrData;
      if (strobes.wrLineCtl)  lineCtl   <= wrData;
      if (strobes.wrModemCtl) modemCtl  <= wrData;
      if (strobes.wrScratch)  scratch   <= wrData;
      if (strobes.wrTxHold)   txData    <= wrData;
      if (strobes.rdStrobe)   rdData    <= rdNext;
    end
  end

  assign divisor = {divHi, divLo};

endmodule

// File: rtl/uart_regfile_top.sv
module uart_regfile_top
  import uart_regs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int DIV_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [OFS_W-1:0]  addr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] rxData,
  input  logic [DATA_W-1:0] intId,
  input  logic [DATA_W-1:0] lineStatus,
  input  logic [DATA_W-1:0] modemStatus,
  output logic              rxPop,
  output logic              txPush,
  output logic [DATA_W-1:0] txData,
  output logic [DIV_W-1:0]  divisor,
  output logic [DATA_W-1:0] intEnable,
  output logic [DATA_W-1:0] fifoCtl,
  output logic              fifoCtlWr,
  output logic [DATA_W-1:0] lineCtl,
  output logic [DATA_W-1:0] modemCtl
);

  regStrobes_t strobes;

  uart_regs_ctrl ctrl_i (
    .addr    (addr),
    .wrEn    (wrEn),
    .rdEn    (rdEn),
    .bankSel (lineCtl[DATA_W-1]),
    .strobes (strobes)
  );

  uart_regs_dp #(.DATA_W(DATA_W)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .wrData      (wrData),
    .rxData      (rxData),
    .intId       (intId),
    .lineStatus  (lineStatus),
    .modemStatus (modemStatus),
    .rdData      (rdData),
    .rxPop       (rxPop),
    .txPush      (txPush),
    .txData      (txData),
    .divisor     (divisor),
    .intEnable   (intEnable),
    .fifoCtl     (fifoCtl),
    .fifoCtlWr   (fifoCtlWr),
    .lineCtl     (lineCtl),
    .modemCtl    (modemCtl)
  );

endmodule

// File: rtl/uart_regs_chk.sv
module uart_regs_chk #(
  parameter int DATA_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic [2:0]          addr,
  input logic                wrEn,
  input logic                rdEn,
  input logic [DATA_W-1:0]   rdData,
  input logic                rxPop,
  input logic                txPush,
  input logic [2*DATA_W-1:0] divisor,
  input logic [DATA_W-1:0]   intEnable,
  input logic [DATA_W-1:0]   fifoCtl,
  input logic                fifoCtlWr,
  input logic [DATA_W-1:0]   lineCtl,
  input logic [DATA_W-1:0]   modemCtl
);

  AST_PUSH_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> $past(wrEn && addr == 3'd0 && !lineCtl[DATA_W-1])); // R2

  AST_POP_SOURCE: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |-> $past(rdEn && addr == 3'd0 && !lineCtl[DATA_W-1])); // R3

  AST_DIVISOR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(wrEn) |-> $stable(divisor)); // R4

  AST_FIFOCTL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    fifoCtlWr |-> $past(wrEn && addr == 3'd2)); // R6

  AST_READONLY_IGNORED: assert property (@(posedge clk) disable iff (!rstN)
    $past(wrEn && (addr == 3'd5 || addr == 3'd6))
      |-> $stable({divisor, intEnable, fifoCtl, lineCtl, modemCtl})); // R8

  AST_RDDATA_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$past(rdEn) |-> $stable(rdData)); // R10

endmodule

bind uart_regfile_top uart_regs_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .addr      (addr),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .rdData    (rdData),
  .rxPop     (rxPop),
  .txPush    (txPush),
  .divisor   (divisor),
  .intEnable (intEnable),
  .fifoCtl   (fifoCtl),
  .fifoCtlWr (fifoCtlWr),
  .lineCtl   (lineCtl),
  .modemCtl  (modemCtl)
);

// File: tb/uart_regfile_tb.sv
module uart_regfile_top_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  addr = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0, rxData = '0, intId = '0, lineStatus = '0, modemStatus = '0;
  logic [7:0]  rdData, txData, intEnable, fifoCtl, lineCtl, modemCtl;
  logic [15:0] divisor;
  logic        rxPop, txPush, fifoCtlWr;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference state
  int mLcr = 0, mIer = 0, mDll = 0, mDlm = 0, mMcr = 0, mScr = 0, mFcr = 0;
  int mRd = 0, mTx = 0;
  bit mPush = 0, mPop = 0, mFcrWr = 0;
  string rdTag = "R1";
  string regTag = "R1";

  always #5 clk = ~clk;

  uart_regfile_top dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .rxData(rxData), .intId(intId),
    .lineStatus(lineStatus), .modemStatus(modemStatus), .rxPop(rxPop),
    .txPush(txPush), .txData(txData), .divisor(divisor), .intEnable(intEnable),
    .fifoCtl(fifoCtl), .fifoCtlWr(fifoCtlWr), .lineCtl(lineCtl), .modemCtl(modemCtl)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic compareAll(input string ovr);
    string rt, gt, st;
    rt = (ovr != "") ? ovr : rdTag;
    gt = (ovr != "") ? ovr : regTag;
    st = (ovr != "") ? ovr : "R2";
    chk(st, "txPush", int'(txPush), int'(mPush));
    chk(st, "txData", int'(txData), mTx);
    chk((ovr != "") ? ovr : "R3", "rxPop", int'(rxPop), int'(mPop));
    chk(rt, "rdData", int'(rdData), mRd);
    chk((gt == "R8" || gt == "R9" || ovr != "") ? gt : "R4", "divisor", int'(divisor), (mDlm << 8) | mDll);
    chk((gt == "R8" || gt == "R9" || ovr != "") ? gt : "R5", "intEnable", int'(intEnable), mIer);
    chk((gt == "R8" || gt == "R9" || ovr != "") ? gt : "R6", "fifoCtl", int'(fifoCtl), mFcr);
    chk((gt == "R8" || gt == "R9" || ovr != "") ? gt : "R6", "fifoCtlWr", int'(fifoCtlWr), int'(mFcrWr));
    chk((gt == "R8" || gt == "R9" || ovr != "") ? gt : "R7", "lineCtl", int'(lineCtl), mLcr);
    chk((gt == "R8" || gt == "R9" || ovr != "") ? gt : "R7", "modemCtl", int'(modemCtl), mMcr);
  endtask

  // reference model: applied at the edge, reads use pre-write state
  task automatic modelEdge();
    bit bank;
    bank   = mLcr[7];
    mPush  = 0;
    mPop   = 0;
    mFcrWr = 0;
    regTag = "";
    if (rdEn) begin
      case (addr)
        3'd0: begin
          if (bank) begin mRd = mDll; rdTag = "R4"; end
          else begin mRd = rxData; mPop = 1; rdTag = "R3"; end
        end
        3'd1: begin mRd = bank ? mDlm : mIer; rdTag = bank ? "R4" : "R5"; end
        3'd2: begin mRd = intId;      rdTag = "R6"; end
        3'd3: begin mRd = mLcr;       rdTag = "R7"; end
        3'd4: begin mRd = mMcr;       rdTag = "R7"; end
        3'd5: begin mRd = lineStatus; rdTag = "R8"; end
        3'd6: begin mRd = modemStatus; rdTag = "R8"; end
        default: begin mRd = mScr;    rdTag = "R9"; end
      endcase
      if (wrEn) rdTag = "R10";
    end else begin
      rdTag = "R10";
    end
    if (wrEn) begin
      case (addr)
        3'd0: if (bank) mDll = wrData; else begin mPush = 1; mTx = wrData; end
        3'd1: if (bank) mDlm = wrData; else mIer = wrData;
        3'd2: begin mFcr = wrData; mFcrWr = 1; end
        3'd3: mLcr = wrData;
        3'd4: mMcr = wrData;
        3'd5, 3'd6: regTag = "R8";
        default: begin mScr = wrData; regTag = "R9"; end
      endcase
    end
  endtask

  task automatic step(input logic [2:0] a, input logic we, input logic re, input logic [7:0] wd);
    @(negedge clk);
    addr = a; wrEn = we; rdEn = re; wrData = wd;
    rxData = 8'($urandom); intId = 8'($urandom);
    lineStatus = 8'($urandom); modemStatus = 8'($urandom);
    @(posedge clk);
    modelEdge();
    #1 compareAll("");
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d); step(a, 1'b1, 1'b0, d); endtask
  task automatic rd(input logic [2:0] a); step(a, 1'b0, 1'b1, 8'h00); endtask
  task automatic idle(); step(3'd0, 1'b0, 1'b0, 8'h00); endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 compareAll("R1");          // R1 during reset
    @(negedge clk) rstN = 1'b1;
    @(posedge clk);
    #1 compareAll("R1");          // R1 after release, no access

    // R1: every held byte readable as zero
    wr(3'd3, 8'h80); rd(3'd0); rd(3'd1); wr(3'd3, 8'h00);
    rd(3'd1); rd(3'd3); rd(3'd4); rd(3'd7);

    // R2: transmit push, back to back and isolated
    wr(3'd0, 8'hA5); idle(); wr(3'd0, 8'h3C); wr(3'd0, 8'hC3); idle();
    // R3: receive pop
    rd(3'd0); idle(); rd(3'd0); rd(3'd0);
    // R4: banked divisor
    wr(3'd3, 8'h83); wr(3'd0, 8'h34); wr(3'd1, 8'h12); rd(3'd0); rd(3'd1);
    wr(3'd3, 8'h03);
    // R5: interrupt enable, bank clear
    wr(3'd1, 8'h0F); rd(3'd1);
    // R6: identification and FIFO control
    rd(3'd2); wr(3'd2, 8'hC7); idle(); rd(3'd2);
    // R7: line and modem control
    wr(3'd4, 8'h1B); rd(3'd4); rd(3'd3);
    // R8: read-only slots ignore writes
    rd(3'd5); rd(3'd6); wr(3'd5, 8'hFF); wr(3'd6, 8'hFF);
    // R9: scratch has no side effect
    wr(3'd7, 8'h5A); rd(3'd7); wr(3'd7, 8'hFF); rd(3'd7);
    // R10: read and write together at the same slot
    step(3'd7, 1'b1, 1'b1, 8'h11); rd(3'd7);
    step(3'd3, 1'b1, 1'b1, 8'h80); step(3'd0, 1'b1, 1'b1, 8'h77);
    step(3'd3, 1'b1, 1'b1, 8'h00);

    // mixed traffic
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] a;
      logic [7:0] d;
      a = 3'($urandom);
      d = 8'($urandom);
      if (a == 3'd3 && ($urandom % 2 == 0)) d[7] = 1'b0;
      step(a, 1'($urandom), 1'($urandom), d);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule